// File: doc/BRIEF.md
# Addressable Switch Node Controller

This block is the network-layer state machine of a slave on a single-wire open-drain bus. It holds a 64-bit identity (8-bit family code in the lowest byte, 48-bit serial number above it, an 8-bit check byte on top), supplied as a parameter. It drives one open-drain output through a pulldown-enable signal. A link layer, outside this block, turns bus slots into single-cycle events: a bus reset, a received bit from a write slot, or a read-slot request. The block answers each read-slot request with one bit. A bit value of 1 means the line is released.

After every bus reset the block takes in an 8-bit command, least significant bit first. The command selects one of four actions:
- Stream out the identity.
- Compare the identity against an address written by the master.
- Join the bus-wide enumeration that uses bit / complement / choice triplets.
- Stay silent.

Selecting the device is itself the control action. A full 64-bit match toggles the pulldown. From then until the next reset, each read slot reports the synchronized level of the external pin.

Top module: `addr_sw_node`

## Requirements
- R1: After rst_n is asserted, pio_pd_o is 0 (pulldown off) and tx_valid_o is 0.
- R2: After a bus reset, the next 8 received bits form a command, least significant bit first. Command 8'h33 means read identity, 8'h55 match identity, 8'hF0 search, and 8'hCC skip.
- R3: After read identity, 64 read slots return the identity bits, bit 0 first. Every later read slot returns 1.
- R4: After match identity, the next 64 received bits are compared with the identity, bit 0 first. An exact match inverts pio_pd_o on the clock edge that accepts the 64th bit.
- R5: During a match, any mismatching bit leaves pio_pd_o unchanged. Every read slot after that returns 1 until a bus reset.
- R6: After a successful match, each read slot returns the external pin level, passed through a 2-stage synchronizer, and not the pulldown register. This continues until a bus reset.
- R7: During search, each identity bit position takes three events in turn: a read slot returning the bit, a read slot returning its complement, then a received bit holding the master's choice.
- R8: A search participant whose bit differs from the master's choice leaves the search. Every read slot after that returns 1 until a bus reset.
- R9: Skip, or any command byte other than the four listed, leaves pio_pd_o unchanged. Every read slot after it returns 1 until a bus reset.
- R10: A bus reset at any point abandons the current sequence and returns to command reception. It takes priority over a bit event in the same cycle.
- R11: tx_valid_o is high in exactly the cycle after a cycle with rd_req_i high, and tx_bit_o holds the answer in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | One-cycle pulse: a bus reset was detected |
| rx_valid_i | input | 1 | One-cycle pulse: a write slot delivered rx_bit_i |
| rx_bit_i | input | 1 | Bit value of the write slot |
| rd_req_i | input | 1 | One-cycle pulse: the master opened a read slot |
| tx_valid_o | output | 1 | Answer to the read slot is valid |
| tx_bit_o | output | 1 | Bit to drive in the read slot (1 = release) |
| pio_in_i | input | 1 | Asynchronous level of the external switch pin |
| pio_pd_o | output | 1 | Pulldown enable of the switch pin (1 = sinking) |

## Verification
The bench checks the toggle in the exact cycle of the 64th matched bit. A design that toggled one bit early or late, or toggled on a near-match that differs only in bit 63, would show a wrong pulldown state there. After a match, the bench holds the pin low from outside while the pulldown is off. A design that reports its own register instead of the synchronized pin answers 1 and is caught. Search is exercised in two ways: a full walk, and a walk where the master picks the opposite bit at one position. A design that kept answering after losing would put identity bits on the line where only 1s belong. Bus resets are applied in the middle of a command byte and in the reporting state, which catches a design that keeps a stale command bit count or stays selected across a reset.

// File: rtl/addr_sw_pkg.sv
package addr_sw_pkg;

    localparam int ID_BITS  = 64;
    localparam int IDX_W    = $clog2(ID_BITS);
    localparam int CMD_BITS = 8;
    localparam int CNT_W    = $clog2(CMD_BITS);

    localparam logic [CMD_BITS-1:0] CMD_READ_ID   = 8'h33;
    localparam logic [CMD_BITS-1:0] CMD_MATCH_ID  = 8'h55;
    localparam logic [CMD_BITS-1:0] CMD_SEARCH_ID = 8'hF0;
    localparam logic [CMD_BITS-1:0] CMD_SKIP_ID   = 8'hCC;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_REPORT,
        ST_IDLE
    } node_state_e;

    typedef enum logic [1:0] {
        PH_BIT,
        PH_CMPL,
        PH_PICK
    } srch_phase_e;

    typedef struct packed {
        node_state_e          state;
        srch_phase_e          phase;
        logic [IDX_W-1:0]     idx;
        logic [CNT_W-1:0]     cmd_cnt;
        logic [CMD_BITS-2:0]  cmd_sr;
        logic                 pd;
        logic                 tx_bit;
        logic                 tx_valid;
    } node_regs_t;

endpackage

// File: rtl/addr_sw_sync.sv
module addr_sw_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= RESET_VAL;
                else        sr_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= {STAGES{RESET_VAL}};
                else        sr_q <= {sr_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/addr_sw_cmd_dec.sv
module addr_sw_cmd_dec
    import addr_sw_pkg::*;
(
    input  logic [CMD_BITS-1:0] code_i,
    output node_state_e         next_o
);
    always_comb begin
        unique case (code_i)
            CMD_READ_ID:   next_o = ST_READ;
            CMD_MATCH_ID:  next_o = ST_MATCH;
            CMD_SEARCH_ID: next_o = ST_SEARCH;
            CMD_SKIP_ID:   next_o = ST_IDLE;
            default:       next_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/addr_sw_bitpick.sv
module addr_sw_bitpick
    import addr_sw_pkg::*;
#(
    parameter logic [ID_BITS-1:0] IDENT = '0
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    logic [ID_BITS-1:0] ident_w;
    assign ident_w = IDENT;
    assign bit_o   = ident_w[idx_i];
endmodule

// File: rtl/addr_sw_node.sv
module addr_sw_node
    import addr_sw_pkg::*;
#(
    parameter logic [ID_BITS-1:0] IDENT       = 64'h9E4A17C3D20B8605,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset_i,
    input  logic rx_valid_i,
    input  logic rx_bit_i,
    input  logic rd_req_i,
    output logic tx_valid_o,
    output logic tx_bit_o,
    input  logic pio_in_i,
    output logic pio_pd_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_BITS - 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);

    node_regs_t  r_q, r_d;
    node_state_e state_q;
    node_state_e dec_state;
    logic        id_bit;
    logic        pin_sync;
    logic        last_bit;

    addr_sw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pio_in_i),
        .q_o   (pin_sync)
    );

    addr_sw_cmd_dec u_dec (
        .code_i ({rx_bit_i, r_q.cmd_sr}),
        .next_o (dec_state)
    );

    addr_sw_bitpick #(.IDENT(IDENT)) u_pick (
        .idx_i (r_q.idx),
        .bit_o (id_bit)
    );

    assign last_bit = (r_q.idx == IDX_LAST);
    assign state_q  = r_q.state;

    always_comb begin
        r_d          = r_q;
        r_d.tx_valid = rd_req_i;
        r_d.tx_bit   = rd_req_i ? 1'b1 : r_q.tx_bit;

        if (bus_reset_i) begin
            r_d.state   = ST_CMD;
            r_d.phase   = PH_BIT;
            r_d.idx     = '0;
            r_d.cmd_cnt = '0;
        end else begin
            unique case (r_q.state)
                ST_CMD: begin
                    if (rx_valid_i) begin
                        if (r_q.cmd_cnt == CMD_LAST) begin
                            r_d.state   = dec_state;
                            r_d.cmd_cnt = '0;
                            r_d.idx     = '0;
                            r_d.phase   = PH_BIT;
                        end else begin
                            r_d.cmd_sr[r_q.cmd_cnt] = rx_bit_i;
                            r_d.cmd_cnt             = r_q.cmd_cnt + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_req_i) begin
                        r_d.tx_bit = id_bit;
                        r_d.idx    = r_q.idx + 1'b1;
                        if (last_bit) r_d.state = ST_IDLE;
                    end
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != id_bit) begin
                            r_d.state = ST_IDLE;
                        end else if (last_bit) begin
                            r_d.state = ST_REPORT;
                            r_d.pd    = ~r_q.pd;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    unique case (r_q.phase)
                        PH_BIT: begin
                            if (rd_req_i) begin
                                r_d.tx_bit = id_bit;
                                r_d.phase  = PH_CMPL;
                            end
                        end
                        PH_CMPL: begin
                            if (rd_req_i) begin
                                r_d.tx_bit = ~id_bit;
                                r_d.phase  = PH_PICK;
                            end
                        end
                        default: begin
                            if (rx_valid_i) begin
                                r_d.phase = PH_BIT;
                                if (rx_bit_i != id_bit || last_bit) r_d.state = ST_IDLE;
                                else r_d.idx = r_q.idx + 1'b1;
                            end
                        end
                    endcase
                end
                ST_REPORT: begin
                    if (rd_req_i) r_d.tx_bit = pin_sync;
                end
                default: begin
                    r_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.phase    <= PH_BIT;
            r_q.idx      <= '0;
            r_q.cmd_cnt  <= '0;
            r_q.cmd_sr   <= '0;
            r_q.pd       <= 1'b0;
            r_q.tx_bit   <= 1'b1;
            r_q.tx_valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid_o = r_q.tx_valid;
    assign tx_bit_o   = r_q.tx_bit;
    assign pio_pd_o   = r_q.pd;
endmodule

// File: rtl/addr_sw_node_chk.sv
module addr_sw_node_chk
    import addr_sw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_reset_i,
    input logic        rx_valid_i,
    input logic        rd_req_i,
    input logic        tx_valid_o,
    input logic        tx_bit_o,
    input logic        pio_pd_o,
    input node_state_e state_q
);
    assert_ack_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> tx_valid_o);

    assert_no_ack_without_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> !tx_valid_o);

    assert_pd_moves_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pio_pd_o) |-> $past(rx_valid_i && state_q == ST_MATCH));

    assert_bus_reset_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> state_q == ST_CMD);

    assert_idle_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !bus_reset_i && state_q == ST_IDLE) |=> tx_bit_o);

    assert_idle_keeps_pd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |=> $stable(pio_pd_o));
endmodule

bind addr_sw_node addr_sw_node_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset_i (bus_reset_i),
    .rx_valid_i  (rx_valid_i),
    .rd_req_i    (rd_req_i),
    .tx_valid_o  (tx_valid_o),
    .tx_bit_o    (tx_bit_o),
    .pio_pd_o    (pio_pd_o),
    .state_q     (state_q)
);

// File: tb/addr_sw_node_bench.sv
`timescale 1ns/1ps
module addr_sw_node_bench;
    localparam logic [63:0] ID = 64'h9E4A17C3D20B8605;
    localparam int NVEC = 6;
    // {command byte, expected first 8 read slots, read i in bit i}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h33, ID[7:0]},                  // R3
        {8'h55, 8'hFF},                    // R5: no answers during match
        {8'hF0, {6'h3F, ~ID[0], ID[0]}},   // R7
        {8'hCC, 8'hFF},                    // R9
        {8'h00, 8'hFF},                    // R9
        {8'hA5, 8'hFF}                     // R9
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset_i = 1'b0, rx_valid_i = 1'b0, rx_bit_i = 1'b0, rd_req_i = 1'b0;
    logic tx_valid_o, tx_bit_o, pio_pd_o;
    logic ext_pull = 1'b1;
    logic pio_in_i;
    int   n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;
    assign pio_in_i = pio_pd_o ? 1'b0 : ext_pull;

    addr_sw_node #(.IDENT(ID)) u_addr_sw_node (
        .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
        .rx_valid_i(rx_valid_i), .rx_bit_i(rx_bit_i), .rd_req_i(rd_req_i),
        .tx_valid_o(tx_valid_o), .tx_bit_o(tx_bit_o),
        .pio_in_i(pio_in_i), .pio_pd_o(pio_pd_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_rst();
        @(negedge clk); bus_reset_i = 1'b1;
        @(negedge clk); bus_reset_i = 1'b0;
    endtask

    task automatic wr(input logic b);
        @(negedge clk); rx_valid_i = 1'b1; rx_bit_i = b;
        @(negedge clk); rx_valid_i = 1'b0;
    endtask

    task automatic rd(output logic b, output logic v);
        @(negedge clk); rd_req_i = 1'b1;
        @(negedge clk); rd_req_i = 1'b0;
        b = tx_bit_o; v = tx_valid_o;
    endtask

    task automatic wr_byte(input logic [7:0] c);
        for (int i = 0; i < 8; i++) wr(c[i]);
    endtask

    task automatic rd_byte(output logic [7:0] c);
        logic b, v;
        for (int i = 0; i < 8; i++) begin rd(b, v); c[i] = b; end
    endtask

    task automatic wr_id(input logic [63:0] w);
        for (int i = 0; i < 64; i++) wr(w[i]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  byt;
        logic [63:0] wa, wb;
        logic        b, v, pd0;

        repeat (3) @(negedge clk);
        check("R1 pulldown off", {63'd0, pio_pd_o}, 64'd0);
        check("R1 no answer", {63'd0, tx_valid_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            bus_rst();
            pd0 = pio_pd_o;
            wr_byte(VEC[k][15:8]);
            rd_byte(byt);
            check($sformatf("R2 vector %0d", k), {56'd0, byt}, {56'd0, VEC[k][7:0]});
            check($sformatf("R9 pd unchanged %0d", k), {63'd0, pio_pd_o}, {63'd0, pd0});
        end

        rd(b, v);
        check("R11 answer strobe", {63'd0, v}, 64'd1);

        // R3 full identity then release
        bus_rst(); wr_byte(8'h33);
        for (int i = 0; i < 64; i++) begin rd(b, v); wa[i] = b; end
        check("R3 identity", wa, ID);
        rd_byte(byt);
        check("R3 released after 64", {56'd0, byt}, 64'hFF);

        // R4 exact match toggles on the 64th bit
        bus_rst(); wr_byte(8'h55);
        for (int i = 0; i < 63; i++) wr(ID[i]);
        check("R4 not before 64th", {63'd0, pio_pd_o}, 64'd0);
        wr(ID[63]);
        check("R4 toggled on", {63'd0, pio_pd_o}, 64'd1);
        repeat (4) @(negedge clk);
        rd(b, v);
        check("R6 pin low reported", {63'd0, b}, 64'd0);

        // R10 reset in report state returns to command reception
        bus_rst(); rd(b, v);
        check("R10 released after reset", {63'd0, b}, 64'd1);

        // second match toggles off; pin held low externally
        bus_rst(); wr_byte(8'h55); wr_id(ID);
        check("R4 toggled off", {63'd0, pio_pd_o}, 64'd0);
        ext_pull = 1'b0;
        repeat (4) @(negedge clk);
        rd(b, v);
        check("R6 live pin not register", {63'd0, b}, 64'd0);
        ext_pull = 1'b1;
        repeat (4) @(negedge clk);
        rd(b, v);
        check("R6 pin high", {63'd0, b}, 64'd1);

        // R5 mismatch at last bit and at first bit
        bus_rst(); wr_byte(8'h55); wr_id(ID ^ (64'd1 << 63));
        check("R5 near match no toggle", {63'd0, pio_pd_o}, 64'd0);
        rd_byte(byt);
        check("R5 released", {56'd0, byt}, 64'hFF);
        bus_rst(); wr_byte(8'h55); wr_id(ID ^ 64'd1);
        check("R5 early mismatch no toggle", {63'd0, pio_pd_o}, 64'd0);

        // R7 full search walk
        bus_rst(); wr_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rd(b, v); wa[i] = b;
            rd(b, v); wb[i] = b;
            wr(ID[i]);
        end
        check("R7 search bits", wa, ID);
        check("R7 search complements", wb, ~ID);
        check("R7 search no toggle", {63'd0, pio_pd_o}, 64'd0);

        // R8 master picks opposite at bit 5
        bus_rst(); wr_byte(8'hF0);
        for (int i = 0; i < 6; i++) begin
            rd(b, v); rd(b, v);
            wr(i == 5 ? ~ID[i] : ID[i]);
        end
        rd(b, v); wa[0] = b; rd(b, v); wa[1] = b;
        check("R8 dropped out", {62'd0, wa[1:0]}, 64'd3);

        // R10 reset in the middle of a command byte
        bus_rst();
        for (int i = 0; i < 4; i++) wr(1'b1);
        bus_rst(); wr_byte(8'h33); rd_byte(byt);
        check("R10 mid-command reset", {56'd0, byt}, {56'd0, ID[7:0]});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule